// File: doc/BRIEF.md
# Self-Refilling Fully Associative Translation Cache

This block caches virtual-to-physical page translations in a small set of fully associative entries. A requester presents a virtual page number. When a valid entry holds that page, the physical frame number is returned in the same cycle. When no entry matches, the block asks an external page table for the mapping over a request/response port. It then either installs the returned mapping or reports a page fault, and passes the outcome back to the requester.

The requester sees a single kind of result, a `resp_valid` pulse with a frame number and a fault flag, whether the translation came from the cache or from the page table. A flush input empties the cache. The default build has 8 entries, a 5-bit virtual page number (32 pages) and a 4-bit frame number (16 frames).

The controller has two states. `ST_IDLE` performs lookups. On an accepted request that misses, transition T1 moves it to `ST_WALK`, where it drives the page-table request and waits. When the page-table response arrives, transition T2 returns it to `ST_IDLE`, in the same cycle as the result and the install. An accepted request that hits stays in `ST_IDLE` (transition T0).

Top module: `tlb_refill`

## Requirements
- R1: A request accepted with `req_valid` and `req_ready` both high whose page number matches a valid entry raises `resp_valid` in that same cycle, with that entry's frame on `resp_ppn` and `resp_fault` low. No page-table request is made for it.
- R2: A request accepted without a match produces no response in the accepting cycle. From the next cycle, `pt_req_valid` is high and `pt_req_vpn` holds the requested page, and both stay steady until `pt_resp_valid`. `req_ready` stays low for that whole time.
- R3: When `pt_resp_valid` is high and `pt_resp_present` is 1, `resp_valid` rises in that same cycle with `resp_ppn` equal to `pt_resp_ppn` and `resp_fault` equal to 0. The mapping is installed, so the next request for that page hits with that frame.
- R4: When `pt_resp_valid` is high and `pt_resp_present` is 0, `resp_valid` and `resp_fault` are both 1 in that cycle. Nothing is installed, so a later request for the same page goes to the page table again.
- R5: An install goes into the lowest-numbered invalid entry. When every entry is valid, it goes into the entry named by a round-robin pointer, which starts at 0 after reset. The pointer advances by one, wrapping after the last entry, only when it has been used.
- R6: A cycle with `flush` high clears every entry, so every later request misses. `req_ready` is low while `flush` is high. An install that falls in a flush cycle is dropped, though the response is still delivered.
- R7: No two valid entries ever hold the same page number. An install for a page already held overwrites that entry in place.
- R8: After reset all entries are invalid and the pointer is 0. `req_ready` is 1, and `resp_valid`, `resp_fault` and `pt_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Translation request present |
| req_vpn | input | VPN_W | Virtual page number to translate |
| req_ready | output | 1 | Block can accept a request this cycle |
| resp_valid | output | 1 | Result pulse |
| resp_ppn | output | PPN_W | Physical frame number of the result |
| resp_fault | output | 1 | Page not present in the page table |
| pt_req_valid | output | 1 | Page-table query outstanding |
| pt_req_vpn | output | VPN_W | Page number being queried |
| pt_resp_valid | input | 1 | Page-table answer present |
| pt_resp_present | input | 1 | Page is mapped in physical memory |
| pt_resp_ppn | input | PPN_W | Frame from the page table |

## Verification
The bench builds the block with its defaults: 8 entries, 5-bit pages and 4-bit frames. With these values, all 32 page numbers are swept several times in different orders. That drives the cache from empty to full and makes the round-robin pointer wrap more than once. A page-table model computes the present flag and the frame number arithmetically from the page number, and varies the answer latency from 0 to 2 cycles. Flushes while idle and in the same cycle as a refill show that state is dropped, and faulting pages show that nothing gets installed.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } walk_state_e;
endpackage

// File: rtl/tlb_repl.sv
module tlb_repl #(
    parameter int ENTRIES = 8,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_i,
    input  logic [ENTRIES-1:0] match_i,
    input  logic               use_i,
    output logic [IDX_W-1:0]   idx_o
);
    logic [IDX_W-1:0] rr_q;
    logic             pick_rr;

    always_comb begin
        logic found;
        found   = 1'b0;
        idx_o   = rr_q;
        pick_rr = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!found && match_i[i]) begin
                idx_o = IDX_W'(i);
                found = 1'b1;
            end
        end
        for (int i = 0; i < ENTRIES; i++) begin
            if (!found && !valid_i[i]) begin
                idx_o = IDX_W'(i);
                found = 1'b1;
            end
        end
        if (!found) pick_rr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (use_i && pick_rr) begin
            if (rr_q == IDX_W'(ENTRIES - 1)) rr_q <= '0;
            else                             rr_q <= rr_q + 1'b1;
        end
    end

    assert_rr_moves_only_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (use_i && (match_i == '0) && (valid_i != {ENTRIES{1'b1}})) |=> $stable(rr_q));
    assert_rr_advances_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (use_i && (match_i == '0) && (valid_i == {ENTRIES{1'b1}})) |=> (rr_q != $past(rr_q)));
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 5,
    parameter int PPN_W   = 4,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PPN_W-1:0] wr_ppn
);
    logic [ENTRIES-1:0] valid_q;
    logic [VPN_W-1:0]   vpn_q [ENTRIES];
    logic [PPN_W-1:0]   ppn_q [ENTRIES];
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] wr_match;
    logic [IDX_W-1:0]   victim;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign lk_match[g] = valid_q[g] && (vpn_q[g] == lk_vpn);
        assign wr_match[g] = valid_q[g] && (vpn_q[g] == wr_vpn);
    end

    assign lk_hit = |lk_match;

    always_comb begin
        lk_ppn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) lk_ppn = lk_ppn | ppn_q[i];
        end
    end

    tlb_repl #(.ENTRIES(ENTRIES)) u_repl (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (valid_q),
        .match_i (wr_match),
        .use_i   (wr_en && !flush),
        .idx_o   (victim)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                vpn_q[i] <= '0;
                ppn_q[i] <= '0;
            end
        end else if (flush) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[victim] <= 1'b1;
            vpn_q[victim]   <= wr_vpn;
            ppn_q[victim]   <= wr_ppn;
        end
    end

    function automatic logic has_dup();
        logic d;
        d = 1'b0;
        for (int i = 0; i < ENTRIES; i++)
            for (int j = i + 1; j < ENTRIES; j++)
                if (valid_q[i] && valid_q[j] && (vpn_q[i] == vpn_q[j])) d = 1'b1;
        return d;
    endfunction

    function automatic logic holds(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p);
        logic h;
        h = 1'b0;
        for (int i = 0; i < ENTRIES; i++)
            if (valid_q[i] && (vpn_q[i] == v) && (ppn_q[i] == p)) h = 1'b1;
        return h;
    endfunction

    assert_unique_vpn_R7: assert property (@(posedge clk) disable iff (!rst_n) !has_dup());
    assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));
    assert_install_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush) |=> holds($past(wr_vpn), $past(wr_ppn)));
endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
    import tlb_pkg::*;
#(
    parameter int VPN_W = 5,
    parameter int PPN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             req_valid,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic             lk_hit,
    input  logic [PPN_W-1:0] lk_ppn,
    input  logic             pt_resp_valid,
    input  logic             pt_resp_present,
    input  logic [PPN_W-1:0] pt_resp_ppn,
    output logic             req_ready,
    output logic             resp_valid,
    output logic [PPN_W-1:0] resp_ppn,
    output logic             resp_fault,
    output logic             pt_req_valid,
    output logic [VPN_W-1:0] pt_req_vpn,
    output logic             wr_en,
    output logic [VPN_W-1:0] wr_vpn,
    output logic [PPN_W-1:0] wr_ppn
);
    walk_state_e      state_q, state_d;
    logic [VPN_W-1:0] vpn_q;
    logic             accept;

    assign accept = req_valid && req_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vpn_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && accept && !lk_hit) vpn_q <= req_vpn;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && !lk_hit) state_d = ST_WALK;
            ST_WALK: if (pt_resp_valid)     state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready    = (state_q == ST_IDLE) && !flush;
        resp_valid   = 1'b0;
        resp_ppn     = '0;
        resp_fault   = 1'b0;
        pt_req_valid = 1'b0;
        wr_en        = 1'b0;
        pt_req_vpn   = vpn_q;
        wr_vpn       = vpn_q;
        wr_ppn       = pt_resp_ppn;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && lk_hit) begin
                    resp_valid = 1'b1;
                    resp_ppn   = lk_ppn;
                end
            end
            ST_WALK: begin
                pt_req_valid = 1'b1;
                if (pt_resp_valid) begin
                    resp_valid = 1'b1;
                    resp_ppn   = pt_resp_ppn;
                    resp_fault = !pt_resp_present;
                    wr_en      = pt_resp_present && !flush;
                end
            end
            default: ;
        endcase
    end

    assert_fault_no_install_R4: assert property (@(posedge clk) disable iff (!rst_n)
        resp_fault |-> !wr_en);
    assert_walk_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_req_valid && !pt_resp_valid) |=> (pt_req_valid && $stable(pt_req_vpn)));
endmodule

// File: rtl/tlb_refill.sv
module tlb_refill #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 5,
    parameter int PPN_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             req_valid,
    input  logic [VPN_W-1:0] req_vpn,
    output logic             req_ready,
    output logic             resp_valid,
    output logic [PPN_W-1:0] resp_ppn,
    output logic             resp_fault,
    output logic             pt_req_valid,
    output logic [VPN_W-1:0] pt_req_vpn,
    input  logic             pt_resp_valid,
    input  logic             pt_resp_present,
    input  logic [PPN_W-1:0] pt_resp_ppn
);
    logic             lk_hit;
    logic [PPN_W-1:0] lk_ppn;
    logic             wr_en;
    logic [VPN_W-1:0] wr_vpn;
    logic [PPN_W-1:0] wr_ppn;

    tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_cam (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (flush),
        .lk_vpn (req_vpn),
        .lk_hit (lk_hit),
        .lk_ppn (lk_ppn),
        .wr_en  (wr_en),
        .wr_vpn (wr_vpn),
        .wr_ppn (wr_ppn)
    );

    tlb_ctrl #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .flush           (flush),
        .req_valid       (req_valid),
        .req_vpn         (req_vpn),
        .lk_hit          (lk_hit),
        .lk_ppn          (lk_ppn),
        .pt_resp_valid   (pt_resp_valid),
        .pt_resp_present (pt_resp_present),
        .pt_resp_ppn     (pt_resp_ppn),
        .req_ready       (req_ready),
        .resp_valid      (resp_valid),
        .resp_ppn        (resp_ppn),
        .resp_fault      (resp_fault),
        .pt_req_valid    (pt_req_valid),
        .pt_req_vpn      (pt_req_vpn),
        .wr_en           (wr_en),
        .wr_vpn          (wr_vpn),
        .wr_ppn          (wr_ppn)
    );

    assert_hit_same_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && lk_hit) |-> (resp_valid && !resp_fault && !pt_req_valid));
    assert_miss_walks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !lk_hit) |=> (pt_req_valid && !req_ready));
    assert_flush_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !req_ready);
endmodule

// File: tb/tlb_refill_tb.sv
module tlb_refill_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES = 8;
    localparam int VPN_W = 5;
    localparam int PPN_W = 4;
    localparam int PAGES = 1 << VPN_W;
    localparam int FRAMES = 1 << PPN_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic req_valid = 1'b0;
    logic [VPN_W-1:0] req_vpn = '0;
    logic req_ready, resp_valid, resp_fault, pt_req_valid;
    logic [PPN_W-1:0] resp_ppn;
    logic [VPN_W-1:0] pt_req_vpn;
    logic pt_resp_valid = 1'b0;
    logic pt_resp_present = 1'b0;
    logic [PPN_W-1:0] pt_resp_ppn = '0;

    int n_checks = 0;
    int n_fail = 0;

    bit m_valid [ENTRIES];
    int m_vpn [ENTRIES];
    int m_ppn [ENTRIES];
    int m_rr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_refill #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_vpn(req_vpn), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_ppn(resp_ppn), .resp_fault(resp_fault),
        .pt_req_valid(pt_req_valid), .pt_req_vpn(pt_req_vpn),
        .pt_resp_valid(pt_resp_valid), .pt_resp_present(pt_resp_present),
        .pt_resp_ppn(pt_resp_ppn)
    );

    function automatic bit pt_has(int v);
        return (v % 3) != 0;
    endfunction

    function automatic int pt_frame(int v);
        return (v * 5 + 3) % FRAMES;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < ENTRIES; i++) m_valid[i] = 1'b0;
    endtask

    task automatic model_install(input int v, input int p);
        int slot;
        slot = -1;
        for (int i = 0; i < ENTRIES; i++)
            if (slot < 0 && m_valid[i] && m_vpn[i] == v) slot = i;
        for (int i = 0; i < ENTRIES; i++)
            if (slot < 0 && !m_valid[i]) slot = i;
        if (slot < 0) begin
            slot = m_rr;
            m_rr = (m_rr + 1) % ENTRIES;
        end
        m_valid[slot] = 1'b1;
        m_vpn[slot] = v;
        m_ppn[slot] = p;
    endtask

    task automatic lookup(input int v, input int lat, input bit flush_mid);
        bit eh;
        int ep;
        eh = 1'b0;
        ep = 0;
        for (int i = 0; i < ENTRIES; i++)
            if (m_valid[i] && m_vpn[i] == v) begin eh = 1'b1; ep = m_ppn[i]; end
        @(negedge clk);
        req_valid = 1'b1;
        req_vpn = VPN_W'(v);
        #1;
        chk(req_ready == 1'b1, "R2 ready in idle", int'(req_ready), 1);
        if (eh) begin
            chk(resp_valid == 1'b1, "R1 hit resp_valid", int'(resp_valid), 1);
            chk(int'(resp_ppn) == ep, "R1 hit ppn", int'(resp_ppn), ep);
            chk(resp_fault == 1'b0, "R1 hit no fault", int'(resp_fault), 0);
            @(posedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            #1;
            chk(pt_req_valid == 1'b0, "R1 hit no walk", int'(pt_req_valid), 0);
        end else begin
            chk(resp_valid == 1'b0, "R2 miss no resp", int'(resp_valid), 0);
            @(posedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            #1;
            chk(pt_req_valid == 1'b1, "R2 walk starts", int'(pt_req_valid), 1);
            chk(int'(pt_req_vpn) == v, "R2 walk vpn", int'(pt_req_vpn), v);
            chk(req_ready == 1'b0, "R2 busy", int'(req_ready), 0);
            for (int k = 0; k < lat; k++) begin
                @(negedge clk);
                #1;
                chk(pt_req_valid == 1'b1 && int'(pt_req_vpn) == v, "R2 walk held",
                    int'(pt_req_vpn), v);
                chk(resp_valid == 1'b0, "R2 no early resp", int'(resp_valid), 0);
            end
            @(negedge clk);
            pt_resp_valid = 1'b1;
            pt_resp_present = pt_has(v);
            pt_resp_ppn = PPN_W'(pt_frame(v));
            flush = flush_mid;
            #1;
            chk(resp_valid == 1'b1, "R3 refill resp_valid", int'(resp_valid), 1);
            if (pt_has(v)) begin
                chk(int'(resp_ppn) == pt_frame(v), "R3 refill ppn", int'(resp_ppn), pt_frame(v));
                chk(resp_fault == 1'b0, "R3 no fault", int'(resp_fault), 0);
            end else begin
                chk(resp_fault == 1'b1, "R4 fault flagged", int'(resp_fault), 1);
            end
            @(posedge clk);
            @(negedge clk);
            pt_resp_valid = 1'b0;
            flush = 1'b0;
            #1;
            chk(req_ready == 1'b1 && pt_req_valid == 1'b0, "R2 back to idle", int'(req_ready), 1);
            if (flush_mid) model_clear();
            else if (pt_has(v)) model_install(v, pt_frame(v));
        end
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        req_valid = 1'b1;
        req_vpn = '0;
        #1;
        chk(req_ready == 1'b0, "R6 ready low in flush", int'(req_ready), 1'b0);
        chk(resp_valid == 1'b0, "R6 no resp in flush", int'(resp_valid), 0);
        @(posedge clk);
        @(negedge clk);
        flush = 1'b0;
        req_valid = 1'b0;
        model_clear();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1 (run completed)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        #1;
        chk(req_ready == 1'b1, "R8 reset ready", int'(req_ready), 1);
        chk(resp_valid == 1'b0 && resp_fault == 1'b0, "R8 reset resp", int'(resp_valid), 0);
        chk(pt_req_valid == 1'b0, "R8 reset no walk", int'(pt_req_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R5, R3, R4: fill from empty, then wrap the pointer several times
        for (int v = 0; v < PAGES; v++) lookup(v, v % 3, 1'b0);
        for (int v = 0; v < PAGES; v++) lookup(v, (v + 1) % 3, 1'b0);
        for (int v = PAGES - 1; v >= 0; v--) lookup(v, 2 - (v % 3), 1'b0);
        // R7: repeated hits to the resident set keep a single copy
        for (int r = 0; r < 3; r++)
            for (int v = 0; v < 4; v++) lookup(v, 0, 1'b0);
        // R6: flush while idle, then everything misses
        do_flush();
        for (int v = 5; v < 12; v++) lookup(v, 1, 1'b0);
        for (int v = 5; v < 12; v++) lookup(v, 1, 1'b0);
        // R6: flush lands with a refill; install is dropped
        lookup(13, 1, 1'b1);
        lookup(13, 0, 1'b0);
        lookup(13, 0, 1'b0);
        // R4: a faulting page keeps faulting
        lookup(9, 0, 1'b0);
        lookup(9, 2, 1'b0);
        // stride pattern across the page space
        for (int v = 0; v < PAGES * 2; v++) lookup((v * 7) % PAGES, v % 3, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule